// File: doc/BRIEF.md
# Multi-Cycle Coprocessor Array Controller

This block sits between a processor and a reconfigurable compute array. The processor talks to it through a single command port that carries three kinds of command. The first selects a configuration by a short name. The second writes one of the two operand registers. The third reads back the result register. Configurations are held in a small resident cache tagged by name. A name that is already resident becomes active with no delay. A name that is not resident costs a fixed load penalty, and the new configuration then takes the place of the entry that was loaded longest ago.

Writing the second operand starts an operation. From that point the controller holds the processor in a stall for a programmed number of cycles. During those cycles the array's stateful stage updates an accumulator once per cycle using the active configuration's arithmetic function. On every step it also issues a memory write through its own memory port, in the same address space the processor uses. The controller holds off any command that arrives during an operation or a configuration load, so the caller keeps it on the port until it is taken.

Top module: `coproc_array_ctrl`

## Requirements
- R1: After reset, cmd_ready is 1 and cpu_stall, mem_req and rd_valid are 0. The active function is the add function (code 0), and no name is resident in the cache.
- R2: A command is taken in a cycle where cmd_valid and cmd_ready are both 1. cmd_op encodes the command: 2'b01 selects a configuration, 2'b10 writes an operand, 2'b11 reads the result, and 2'b00 does nothing. For an operand write, cmd_sel=0 writes operand A and does not start an operation. cmd_sel=1 writes operand B and starts an operation of cmd_count cycles.
- R3: A configuration command whose name is resident (a hit) with cmd_sel=0 makes that name active. cmd_ready stays 1 in the cycle after it is taken.
- R4: A configuration command whose name is not resident (a miss) holds cmd_ready at 0 for exactly 16 cycles after it is taken. The name is then inserted into a 4-entry cache in place of the entry loaded longest ago. Hits do not change that order.
- R5: A configuration command with cmd_sel=1 only makes the name resident. On a miss it still costs the 16-cycle load. In either case the active function does not change.
- R6: cpu_stall is 1 from the cycle after a starting operand write for exactly cmd_count cycles, with a count of 0 treated as 1. cmd_ready is 0 over those same cycles.
- R7: The operation sets the accumulator to A and then applies one step per stall cycle. The step is chosen by the low two bits of the active name: 0 adds B, 1 subtracts B, 2 XORs with B, and 3 rotates the accumulator left by one bit and XORs the result with B.
- R8: In the k-th stall cycle (k from 0), mem_req is 1, mem_addr is the low 16 bits of A plus k, and mem_wdata is the accumulator value before step k. mem_req is 0 outside the stall.
- R9: A result read returns the accumulator on rd_data, with rd_valid high, in the cycle after the read is taken. A read issued while an operation runs is held until the stall ends and then returns the final result.
- R10: A configuration command issued while an operation runs is held until the stall ends. The operation in flight keeps the function it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller can take a command this cycle |
| cmd_op | input | 2 | Command code |
| cmd_sel | input | 1 | Operand select, or preload-only flag for configure |
| cmd_name | input | 6 | Configuration name |
| cmd_data | input | 32 | Operand value |
| cmd_count | input | 8 | Operation length in cycles |
| rd_valid | output | 1 | Result on rd_data this cycle |
| rd_data | output | 32 | Result value |
| cpu_stall | output | 1 | Processor suspend |
| mem_req | output | 1 | Array memory write request |
| mem_addr | output | 16 | Array memory address |
| mem_wdata | output | 32 | Array memory write data |

## Verification
The assertions assume the caller follows the valid/ready rule on the command port: it holds a command until it is taken, and it uses only the defined cmd_op codes. The cache assertions also assume that a name is resident at most once, which the controller ensures because it inserts a name only after a miss. The bench drives every input on the falling edge and keeps each command on the port until the cycle it is taken. Its cache scenarios are ordered by hand, so each expected hit or miss follows from the load order alone.

// File: rtl/coproc_pkg.sv
// Shared types for the coprocessor array controller.
// Assumes: command codes and function codes are fixed 2-bit encodings.
package coproc_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'b00,
        CMD_CFG  = 2'b01,
        CMD_TO   = 2'b10,
        CMD_FROM = 2'b11
    } cmd_t;

    typedef enum logic [1:0] {
        FN_ADD = 2'b00,
        FN_SUB = 2'b01,
        FN_XOR = 2'b10,
        FN_ROT = 2'b11
    } fn_t;

endpackage

// File: rtl/cfg_tag_cache.sv
// Resident configuration tags. Compares the looked-up name against every
// valid entry. An insert overwrites the entry loaded longest ago (first-in
// order, which hits do not disturb).
// Assumes: insert is only raised for a name that missed.
module cfg_tag_cache #(
    parameter int ENTRIES = 4,
    parameter int NAME_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NAME_W-1:0] look_name,
    output logic              hit,
    input  logic              ins_en,
    input  logic [NAME_W-1:0] ins_name
);
    localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [NAME_W-1:0]  tag_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] match;
    logic [PW-1:0]      victim_q;

    // Per-entry tag comparison.
    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
            assign match[e] = vld_q[e] && (tag_q[e] == look_name);
        end
    endgenerate

    assign hit = |match;

    // Tag storage and victim pointer update on insert.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q    <= '0;
            victim_q <= '0;
            for (int e = 0; e < ENTRIES; e++) tag_q[e] <= '0;
        end else if (ins_en) begin
            tag_q[victim_q] <= ins_name;
            vld_q[victim_q] <= 1'b1;
            victim_q <= (victim_q == PW'(ENTRIES - 1)) ? '0 : victim_q + 1'b1;
        end
    end

    // R4: a name is never resident twice.
    a_r4_unique_tags: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R4: every insert advances the victim pointer.
    a_r4_victim_moves: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |=> victim_q != $past(victim_q));

endmodule

// File: rtl/busy_counter.sv
// Down counter that is busy while non-zero. A load of zero is taken as one.
// Assumes: load is not raised while the counter is busy.
module busy_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy,
    output logic         last
);
    logic [W-1:0] cnt_q;

    assign busy = (cnt_q != '0);
    assign last = (cnt_q == W'(1));

    // Load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= (load_val == '0) ? W'(1) : load_val;
        else if (busy)
            cnt_q <= cnt_q - 1'b1;
    end

    // R6: a busy counter loses exactly one per cycle.
    a_r6_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> cnt_q == $past(cnt_q) - 1'b1);

    // R6: a load never leaves the counter idle.
    a_r6_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);

endmodule

// File: rtl/array_stage.sv
// Stateful arithmetic stage standing in for the configured array. On start
// it captures A, B and the function. On each step it updates the accumulator
// and exposes the memory write for that step.
// Assumes: start and step are never raised together.
module array_stage
    import coproc_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] b_in,
    input  fn_t           fn_in,
    input  logic          step,
    output logic [DW-1:0] acc,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata
);
    logic [DW-1:0] acc_q, b_q;
    logic [AW-1:0] base_q, idx_q;
    fn_t           fn_q;
    logic [DW-1:0] acc_nx;

    // Step function chosen by the captured function code.
    always_comb begin
        case (fn_q)
            FN_ADD:  acc_nx = acc_q + b_q;
            FN_SUB:  acc_nx = acc_q - b_q;
            FN_XOR:  acc_nx = acc_q ^ b_q;
            default: acc_nx = {acc_q[DW-2:0], acc_q[DW-1]} ^ b_q;
        endcase
    end

    // Operand capture on start, accumulate and index on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            b_q    <= '0;
            base_q <= '0;
            idx_q  <= '0;
            fn_q   <= FN_ADD;
        end else if (start) begin
            acc_q  <= a_in;
            b_q    <= b_in;
            base_q <= a_in[AW-1:0];
            idx_q  <= '0;
            fn_q   <= fn_in;
        end else if (step) begin
            acc_q <= acc_nx;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign acc   = acc_q;
    assign addr  = base_q + idx_q;
    assign wdata = acc_q;

    // R10: the function stays fixed while steps run.
    a_r10_fn_held: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start) |=> $stable(fn_q));

    // R8: addresses advance by one per step.
    a_r8_addr_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start) |=> addr == $past(addr) + 1'b1);

endmodule

// File: rtl/coproc_array_ctrl.sv
// Controller for a reconfigurable coprocessor array. It decodes configure,
// operand-write and result-read commands, manages the resident configuration
// cache with its miss penalty, stalls the processor for the programmed
// operation length, and drives the array's memory writes.
// Assumes: the caller holds a command on the port until it is taken.
module coproc_array_ctrl
    import coproc_pkg::*;
#(
    parameter int DW       = 32,
    parameter int AW       = 16,
    parameter int NAME_W   = 6,
    parameter int CW       = 8,
    parameter int ENTRIES  = 4,
    parameter int LOAD_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_sel,
    input  logic [NAME_W-1:0] cmd_name,
    input  logic [DW-1:0]     cmd_data,
    input  logic [CW-1:0]     cmd_count,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata
);
    localparam int LW = $clog2(LOAD_CYC + 1);

    logic              take, take_cfg, take_to, take_from, start;
    logic              hit, run_busy, run_last, ld_busy, ld_last;
    logic [DW-1:0]     opa_q, acc;
    logic [NAME_W-1:0] pend_name_q;
    logic              pend_act_q;
    fn_t               active_q;

    assign cmd_ready = !run_busy && !ld_busy;
    assign take      = cmd_valid && cmd_ready;
    assign take_cfg  = take && (cmd_op == CMD_CFG);
    assign take_to   = take && (cmd_op == CMD_TO);
    assign take_from = take && (cmd_op == CMD_FROM);
    assign start     = take_to && cmd_sel;

    cfg_tag_cache #(.ENTRIES(ENTRIES), .NAME_W(NAME_W)) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_name (cmd_name),
        .hit       (hit),
        .ins_en    (ld_last),
        .ins_name  (pend_name_q)
    );

    busy_counter #(.W(LW)) u_load_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_cfg && !hit),
        .load_val (LW'(LOAD_CYC)),
        .busy     (ld_busy),
        .last     (ld_last)
    );

    busy_counter #(.W(CW)) u_run_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (cmd_count),
        .busy     (run_busy),
        .last     (run_last)
    );

    array_stage #(.DW(DW), .AW(AW)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .a_in  (opa_q),
        .b_in  (cmd_data),
        .fn_in (active_q),
        .step  (run_busy),
        .acc   (acc),
        .addr  (mem_addr),
        .wdata (mem_wdata)
    );

    // Active function, pending miss and operand A bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q    <= FN_ADD;
            pend_name_q <= '0;
            pend_act_q  <= 1'b0;
            opa_q       <= '0;
        end else begin
            if (take_cfg && hit && !cmd_sel)
                active_q <= fn_t'(cmd_name[1:0]);
            if (take_cfg && !hit) begin
                pend_name_q <= cmd_name;
                pend_act_q  <= !cmd_sel;
            end
            if (ld_last && pend_act_q)
                active_q <= fn_t'(pend_name_q[1:0]);
            if (take_to && !cmd_sel)
                opa_q <= cmd_data;
        end
    end

    // Result read response, one cycle after the read is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= take_from;
            if (take_from) rd_data <= acc;
        end
    end

    assign cpu_stall = run_busy;
    assign mem_req   = run_busy;

    // R6: a starting operand write stalls the processor next cycle.
    a_r6_start_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> cpu_stall);

    // R6: the stall ends one cycle after the last counted cycle.
    a_r6_stall_ends: assert property (@(posedge clk) disable iff (!rst_n)
        run_last |=> !cpu_stall);

    // R4: a miss blocks the command port on the next cycle.
    a_r4_miss_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (take_cfg && !hit) |=> !cmd_ready);

    // R9: a result response always follows a taken read.
    a_r9_rd_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(take_from));

    // R10: no command is taken while the array runs.
    a_r10_hold_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> !take);

endmodule

// File: tb/coproc_array_ctrl_bench.sv
// Directed bench for the coprocessor array controller.
module coproc_array_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'b00;
    logic        cmd_sel = 1'b0;
    logic [5:0]  cmd_name = '0;
    logic [31:0] cmd_data = '0;
    logic [7:0]  cmd_count = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        cpu_stall, mem_req;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;
    logic [1:0] cur_fn = 2'd0;

    coproc_array_ctrl u_coproc_array_ctrl (.*);

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] step_fn(input logic [1:0] f, input logic [31:0] a,
                                             input logic [31:0] b);
        case (f)
            2'd0: return a + b;
            2'd1: return a - b;
            2'd2: return a ^ b;
            default: return {a[30:0], a[31]} ^ b;
        endcase
    endfunction

    // Presents one command at a falling edge and returns at the falling edge
    // after it is taken; waited counts falling edges spent with ready low.
    task automatic send(input logic [1:0] op, input logic sel, input logic [5:0] nm,
                        input logic [31:0] d, input logic [7:0] n, output int waited);
        cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel; cmd_name = nm;
        cmd_data = d; cmd_count = n; waited = 0;
        while (!cmd_ready) begin @(negedge clk); waited++; end
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
    endtask

    // Configure and measure the busy cycles that follow.
    task automatic configure(input logic [5:0] nm, input logic preload, input int exp_busy,
                             input string req);
        int w, busy;
        send(2'b01, preload, nm, '0, '0, w);
        busy = 0;
        while (!cmd_ready && busy < 40) begin busy++; @(negedge clk); end
        chk(req, busy, exp_busy);
        if (!preload) cur_fn = nm[1:0];
    endtask

    // R2 R6 R7 R8 R9: one full operation with stall, memory and result checks.
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [7:0] n);
        int w, eff;
        logic [31:0] acc;
        send(2'b10, 1'b0, '0, a, '0, w);
        chk("R2 operand A write does not stall", cpu_stall, 1'b0);
        send(2'b10, 1'b1, '0, b, n, w);
        eff = (n == 0) ? 1 : int'(n);
        acc = a;
        for (int k = 0; k < eff; k++) begin
            chk("R6 stall during run", {cpu_stall, cmd_ready}, 2'b10);
            chk("R8 mem request", {mem_req, mem_addr}, {1'b1, a[15:0] + 16'(k)});
            chk("R8 mem write data", mem_wdata, acc);
            acc = step_fn(cur_fn, acc, b);
            @(negedge clk);
        end
        chk("R6 stall released after count", {cpu_stall, mem_req, cmd_ready}, 3'b001);
        send(2'b11, 1'b0, '0, '0, '0, w);
        chk("R9 rd_valid after read", rd_valid, 1'b1);
        chk("R7 result", rd_data, acc);
    endtask

    task automatic t_reset();
        chk("R1 reset outputs", {cmd_ready, cpu_stall, mem_req, rd_valid}, 4'b1000);
        cur_fn = 2'd0;
        run_op(32'd10, 32'd7, 8'd3);
    endtask

    task automatic t_cache();
        configure(6'd5, 1'b0, 16, "R4 miss penalty name 5");
        run_op(32'd100, 32'd3, 8'd4);
        configure(6'd5, 1'b0, 0, "R3 hit no penalty");
        configure(6'd2, 1'b1, 16, "R5 preload miss penalty");
        run_op(32'd50, 32'd6, 8'd2);
        configure(6'd2, 1'b0, 0, "R5 preloaded name hits");
        run_op(32'hF0F0, 32'h0FF0, 8'd5);
        configure(6'd7, 1'b1, 16, "R4 fill 7");
        configure(6'd12, 1'b1, 16, "R4 fill 12");
        configure(6'd7, 1'b0, 0, "R3 hit 7");
        run_op(32'h8000_0001, 32'h3, 8'd6);
        configure(6'd5, 1'b0, 0, "R3 hit 5 before eviction");
        configure(6'd9, 1'b0, 16, "R4 miss 9 evicts oldest");
        configure(6'd2, 1'b0, 0, "R4 2 still resident");
        configure(6'd5, 1'b0, 16, "R4 5 evicted despite recent hit");
        configure(6'd2, 1'b0, 16, "R4 2 evicted by reload of 5");
        run_op(32'd1000, 32'd9, 8'd3);
    endtask

    task automatic t_zero_count();
        run_op(32'd77, 32'd1, 8'd0);
    endtask

    task automatic t_read_held();
        int w;
        logic [31:0] acc;
        send(2'b10, 1'b0, '0, 32'd20, '0, w);
        send(2'b10, 1'b1, '0, 32'd4, 8'd6, w);
        acc = 32'd20;
        for (int k = 0; k < 6; k++) acc = step_fn(cur_fn, acc, 32'd4);
        send(2'b11, 1'b0, '0, '0, '0, w);
        chk("R9 read held until stall ends", w, 6);
        chk("R9 held read returns final result", {rd_valid, rd_data}, {1'b1, acc});
    endtask

    task automatic t_cfg_held();
        int w;
        logic [31:0] acc;
        logic [1:0] old_fn;
        old_fn = cur_fn;
        send(2'b10, 1'b0, '0, 32'd40, '0, w);
        send(2'b10, 1'b1, '0, 32'd5, 8'd3, w);
        send(2'b01, 1'b0, 6'd9, '0, '0, w);
        chk("R10 configure held during run", w, 3);
        chk("R10 hit after run no penalty", cmd_ready, 1'b1);
        cur_fn = 2'd1;
        acc = 32'd40;
        for (int k = 0; k < 3; k++) acc = step_fn(old_fn, acc, 32'd5);
        send(2'b11, 1'b0, '0, '0, '0, w);
        chk("R10 in-flight run kept old function", rd_data, acc);
        run_op(32'd300, 32'd11, 8'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cache();
        t_zero_count();
        t_read_held();
        t_cfg_held();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule